// File: doc/BRIEF.md
# Programmable Reference-Compare Timer

A 16-bit up-counting timer that divides the system clock by a programmable amount and compares its count against a reference value. When a counting tick finds the counter at the reference value, the timer latches a reference event. Depending on the mode, the counter then either restarts at zero or keeps running and wraps at the top of its range. An interrupt line follows the latched reference event, but only while the reference interrupt is enabled in the mode register.

Software controls the timer through a plain synchronous register port. Writes take effect on the rising clock edge when `wr_en` is high. `rd_data` is a combinational function of `addr` and of the current register state. The port carries no stream of data, so it has no valid/ready handshake and never applies back-pressure: every write is accepted in the cycle it is presented. The capture register is plain read/write storage.

Top module: `refcmp_timer`

## Requirements
- R1: Writing the control register (byte offset 0x00) with bit 0 = 0 while its stored bit 0 is 1 leaves both the control register and the reference register (0x04) at zero. Writing bit 0 = 0 while it is already 0 stores the written value unchanged.
- R2: The counter advances only when control bit 0 (enable) is 1 and control bits 2:1 (source) are 1 or 2. Source values 0 and 3, or enable = 0, hold the counter at its value.
- R3: With source = 1 the counter advances once every P+1 clocks. With source = 2 it advances once every 16*(P+1) clocks. P is control bits 15:8, so P+1 ranges from 1 to 256.
- R4: With control bit 3 (restart) set, a tick that finds the counter equal to the reference value loads zero. The counter therefore cycles through reference+1 values.
- R5: `irq` is high exactly when control bit 4 (reference interrupt enable) is 1 and event bit 1 is 1.
- R6: A tick that finds the counter equal to the reference value sets event register (offset 0x11) bit 1. Event bit 0 is the capture flag. The two event bits read back in bits 1:0.
- R7: Writing the event register clears each event bit whose written bit is 1 and leaves the others unchanged. A reference event set in the same cycle wins over the clear.
- R8: Offsets 0x00 control, 0x04 reference, 0x08 capture, 0x0C counter and 0x11 event are readable. The capture register returns what was written to it. Any other offset reads zero.
- R9: A write to offset 0x0C loads the counter with the written value in that cycle, taking priority over a tick in the same cycle.
- R10: With restart clear, the counter wraps from 0xFFFF to 0x0000 and still sets event bit 1 on each tick that finds it equal to the reference value.
- R11: Any write to the control or reference register restarts the clock divider, so the next tick comes a full divide period after that write.
- R12: After reset, every register reads zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | Reference interrupt request |

## Verification
The assertions take for granted that `addr`, `wr_en` and `wr_data` are stable around each rising edge. They also assume that a change of prescale or source arrives only through a control write, which realigns the divider. The bench therefore changes inputs only on falling edges, and it changes timing settings only through control writes. Before any reprogramming it stops the counter with a disabling control write, so that no settings change under a running divider.

// File: rtl/refcmp_timer_pkg.sv
package refcmp_timer_pkg;

  localparam int CNT_W = 16;
  localparam int PRE_W = 8;
  localparam int EV_W  = 2;
  localparam int EV_REF_BIT = 1;

  typedef enum logic [1:0] {
    SRC_OFF_A = 2'd0,
    SRC_SYS   = 2'd1,
    SRC_SLOW  = 2'd2,
    SRC_OFF_B = 2'd3
  } clk_src_e;

  typedef struct packed {
    logic [PRE_W-1:0] prescale;
    logic [2:0]       spare;
    logic             ref_irq_en;
    logic             restart;
    clk_src_e         src;
    logic             enable;
  } ctrl_t;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_REF  = 8'h04;
  localparam logic [7:0] OFS_CAP  = 8'h08;
  localparam logic [7:0] OFS_CNT  = 8'h0C;
  localparam logic [7:0] OFS_EVT  = 8'h11;

endpackage

// File: rtl/rct_prescaler.sv
module rct_prescaler #(
  parameter int PRE_W      = 8,
  parameter int SLOW_SHIFT = 4,
  localparam int PH_W      = PRE_W + SLOW_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             slow,
  input  logic [PRE_W-1:0] prescale,
  input  logic             realign,
  output logic             tick
);

  logic [PH_W:0]   base;
  logic [PH_W:0]   div_m1;
  logic [PH_W-1:0] phase_q;

  always_comb begin
    base   = (PH_W+1)'(prescale) + (PH_W+1)'(1);
    div_m1 = (slow ? (base << SLOW_SHIFT) : base) - (PH_W+1)'(1);
  end

  assign tick = run && !realign && (phase_q == div_m1[PH_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase_q <= '0;
    else if (realign || !run)  phase_q <= '0;
    else if (tick)             phase_q <= '0;
    else                       phase_q <= phase_q + 1'b1;
  end

  // R3: the divider phase never runs beyond its period
  p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, phase_q} <= div_m1);

  // R11: a realign returns the phase to zero on the next cycle
  p_realign_r11: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> (phase_q == '0));

endmodule

// File: rtl/rct_counter.sv
module rct_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] ref_val,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             match
);

  logic [CNT_W-1:0] count_q;
  logic             at_ref;

  assign at_ref = (count_q == ref_val);
  assign match  = tick && at_ref;
  assign count  = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count_q <= '0;
    else if (load)               count_q <= load_val;
    else if (tick && restart && at_ref) count_q <= '0;
    else if (tick)               count_q <= count_q + 1'b1;
  end

  // R2: without tick or load the count is held
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count_q));

  // R4: restart returns to zero after a reference hit
  p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && restart && at_ref && !load) |=> (count_q == '0));

  // R10: free running increments with wrap
  p_free_inc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && !load) |=> (count_q == CNT_W'($past(count_q) + 1'b1)));

  // R9: a load wins over everything
  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count_q == $past(load_val)));

endmodule

// File: rtl/rct_events.sv
module rct_events #(
  parameter int EV_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] set_vec,
  input  logic            clr_wr,
  input  logic [EV_W-1:0] clr_mask,
  output logic [EV_W-1:0] flags
);

  logic [EV_W-1:0] flags_q;

  for (genvar b = 0; b < EV_W; b++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     flags_q[b] <= 1'b0;
      else if (set_vec[b])            flags_q[b] <= 1'b1;
      else if (clr_wr && clr_mask[b]) flags_q[b] <= 1'b0;
    end

    // R7: a one in the clear mask clears the flag unless it is set again
    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_mask[b] && !set_vec[b]) |=> !flags_q[b]);

    // R7: a zero in the clear mask never drops the flag
    p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[b] && !(clr_wr && clr_mask[b])) |=> flags_q[b]);

    // R6: a set request always leaves the flag high
    p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[b] |=> flags_q[b]);
  end

  assign flags = flags_q;

endmodule

// File: rtl/refcmp_timer.sv
module refcmp_timer
  import refcmp_timer_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int SLOW_SHIFT = 4,
  localparam int DATA_W    = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] ref_q;
  logic [CNT_W-1:0] cap_q;
  logic [CNT_W-1:0] count;
  logic [EV_W-1:0]  flags;
  logic [EV_W-1:0]  set_vec;
  logic             wr_ctrl, wr_ref, wr_cap, wr_cnt, wr_evt;
  logic             shutdown;
  logic             run, slow, tick, match;

  assign wr_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign wr_ref  = wr_en && (addr == ADDR_W'(OFS_REF));
  assign wr_cap  = wr_en && (addr == ADDR_W'(OFS_CAP));
  assign wr_cnt  = wr_en && (addr == ADDR_W'(OFS_CNT));
  assign wr_evt  = wr_en && (addr == ADDR_W'(OFS_EVT));

  assign shutdown = wr_ctrl && ctrl_q.enable && !wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ref_q  <= '0;
      cap_q  <= '0;
    end else begin
      if (shutdown) begin
        ctrl_q <= '0;
        ref_q  <= '0;
      end else begin
        if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data);
        if (wr_ref)  ref_q  <= wr_data;
      end
      if (wr_cap) cap_q <= wr_data;
    end
  end

  assign run  = ctrl_q.enable && ((ctrl_q.src == SRC_SYS) || (ctrl_q.src == SRC_SLOW));
  assign slow = (ctrl_q.src == SRC_SLOW);

  rct_prescaler #(
    .PRE_W      (PRE_W),
    .SLOW_SHIFT (SLOW_SHIFT)
  ) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .slow     (slow),
    .prescale (ctrl_q.prescale),
    .realign  (wr_ctrl || wr_ref),
    .tick     (tick)
  );

  rct_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .restart  (ctrl_q.restart),
    .ref_val  (ref_q),
    .load     (wr_cnt),
    .load_val (wr_data),
    .count    (count),
    .match    (match)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[EV_REF_BIT] = match;
  end

  rct_events #(
    .EV_W (EV_W)
  ) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_wr   (wr_evt),
    .clr_mask (wr_data[EV_W-1:0]),
    .flags    (flags)
  );

  assign irq = ctrl_q.ref_irq_en && flags[EV_REF_BIT];

  always_comb begin
    rd_data = '0;
    case (addr)
      ADDR_W'(OFS_CTRL): rd_data = DATA_W'(ctrl_q);
      ADDR_W'(OFS_REF):  rd_data = ref_q;
      ADDR_W'(OFS_CAP):  rd_data = cap_q;
      ADDR_W'(OFS_CNT):  rd_data = count;
      ADDR_W'(OFS_EVT):  rd_data = DATA_W'(flags);
      default:           rd_data = '0;
    endcase
  end

  // R1: disabling a running timer wipes control and reference
  p_dis_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> (ctrl_q == '0 && ref_q == '0));

  // R5: no interrupt while the reference interrupt is disabled
  p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.ref_irq_en |-> !irq);

  // R2: no tick while the timer is stopped
  p_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);

endmodule

// File: tb/refcmp_timer_tb_top.sv
module refcmp_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  refcmp_timer dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq     (irq)
  );

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL R0 watchdog actual=%0d expected<150000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  // entered and left at a falling edge; consumes exactly one rising edge
  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic step(input int k);
    for (int i = 0; i < k; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  function automatic logic [15:0] mk(input int p, input int src, input bit rs, input bit ori);
    return {p[7:0], 3'b000, ori, rs, src[1:0], 1'b1};
  endfunction

  task automatic setup(input logic [15:0] rv, input logic [15:0] cv, input logic [15:0] m);
    wr(8'h00, 16'h0000);
    wr(8'h04, rv);
    wr(8'h0C, cv);
    wr(8'h11, 16'h0003);
    wr(8'h00, m);
  endtask

  initial begin
    int v;
    int div;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    rd(8'h00, v); check("R12 ctrl", v, 0);
    rd(8'h04, v); check("R12 ref", v, 0);
    rd(8'h08, v); check("R12 cap", v, 0);
    rd(8'h0C, v); check("R12 cnt", v, 0);
    rd(8'h11, v); check("R12 evt", v, 0);
    check("R12 irq", int'(irq), 0);

    // R8 map and capture storage
    wr(8'h08, 16'hBEEF);
    rd(8'h08, v); check("R8 capture", v, 16'hBEEF);
    rd(8'h10, v); check("R8 unmapped 10", v, 0);
    rd(8'h12, v); check("R8 unmapped 12", v, 0);
    rd(8'h20, v); check("R8 unmapped 20", v, 0);

    // R3 divider sweep
    for (int src = 1; src <= 2; src++) begin
      for (int pi = 0; pi <= 8; pi++) begin
        int p = (pi == 8) ? 255 : pi;
        div = (p + 1) * ((src == 2) ? 16 : 1);
        setup(16'hFFFF, 16'h0000, mk(p, src, 1'b0, 1'b0));
        step(div - 1);
        rd(8'h0C, v); check("R3 before first tick", v, 0);
        step(1);
        rd(8'h0C, v); check("R3 first tick", v, 1);
        step(2 * div);
        rd(8'h0C, v); check("R3 third tick", v, 3);
      end
    end

    // R2 stopped sources and disabled timer
    setup(16'hFFFF, 16'h0005, mk(0, 0, 1'b0, 1'b0));
    step(20);
    rd(8'h0C, v); check("R2 source 0 holds", v, 5);
    setup(16'hFFFF, 16'h0005, mk(0, 3, 1'b0, 1'b0));
    step(20);
    rd(8'h0C, v); check("R2 source 3 holds", v, 5);

    // R1 disable clears control and reference
    setup(16'h0123, 16'h0000, mk(0, 1, 1'b0, 1'b1));
    wr(8'h00, 16'h0010);
    rd(8'h00, v); check("R1 ctrl cleared", v, 0);
    rd(8'h04, v); check("R1 ref cleared", v, 0);
    wr(8'h00, 16'h0A06);
    rd(8'h00, v); check("R1 store when disabled", v, 16'h0A06);
    rd(8'h0C, v);
    step(10);
    begin
      int v2;
      rd(8'h0C, v2); check("R2 disabled holds", v2, v);
    end

    // R4 R6 R5 restart sweep with interrupt enabled
    for (int r = 0; r <= 4; r++) begin
      setup(16'(r), 16'h0000, mk(0, 1, 1'b1, 1'b1));
      for (int k = 1; k <= 3 * (r + 1); k++) begin
        step(1);
        rd(8'h0C, v); check("R4 restart count", v, k % (r + 1));
        rd(8'h11, v); check("R6 ref flag", v, (k >= r + 1) ? 2 : 0);
        check("R5 irq follows flag", int'(irq), (k >= r + 1) ? 1 : 0);
      end
    end

    // R5 gate, R7 clear rules
    setup(16'h0002, 16'h0000, mk(0, 1, 1'b1, 1'b0));
    step(5);
    rd(8'h11, v); check("R6 flag with irq off", v, 2);
    check("R5 irq gated off", int'(irq), 0);
    wr(8'h00, 16'h0019);
    check("R5 irq on when enabled", int'(irq), 1);
    wr(8'h11, 16'h0001);
    rd(8'h11, v); check("R7 zero mask keeps flag", v, 2);
    check("R7 irq kept", int'(irq), 1);
    wr(8'h11, 16'h0002);
    rd(8'h11, v); check("R7 one mask clears flag", v, 0);
    check("R7 irq dropped", int'(irq), 0);

    // R10 wrap in free-running mode
    setup(16'h0001, 16'hFFFD, mk(0, 1, 1'b0, 1'b0));
    step(3);
    rd(8'h0C, v); check("R10 wrap to zero", v, 0);
    step(1);
    rd(8'h0C, v); check("R10 after wrap", v, 1);
    rd(8'h11, v); check("R10 no flag yet", v, 0);
    step(1);
    rd(8'h0C, v); check("R10 passes ref", v, 2);
    rd(8'h11, v); check("R10 flag after ref", v, 2);

    // R9 direct load
    setup(16'hFFFF, 16'h0000, mk(0, 1, 1'b0, 1'b0));
    step(3);
    rd(8'h0C, v); check("R9 running", v, 3);
    wr(8'h0C, 16'h1234);
    rd(8'h0C, v); check("R9 loaded", v, 16'h1234);
    step(1);
    rd(8'h0C, v); check("R9 counts from load", v, 16'h1235);

    // R11 reference write realigns the divider
    setup(16'hFFFF, 16'h0000, mk(3, 1, 1'b0, 1'b0));
    step(2);
    wr(8'h04, 16'hFFFF);
    step(3);
    rd(8'h0C, v); check("R11 no early tick", v, 0);
    step(1);
    rd(8'h0C, v); check("R11 tick full period later", v, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule